// File: doc/BRIEF.md
# Interval Timer with Count Snapshot

This block is a free-running interval timer that sits on a 16-bit memory-mapped register bus. It holds a 32-bit counter that advances by one each clock cycle while the timer is running, and a 32-bit period. When the counter equals the period, a sticky timeout flag is raised. If the interrupt enable bit is set, the flag drives the interrupt line. Software reaches every 32-bit quantity through a low and a high 16-bit register. A write to either snapshot register copies the live count into a 32-bit holding register. Software can then read both halves of that copy without the count moving underneath it.

The timer has two modes. In continuous mode the counter goes back to zero on a match and keeps counting, so a period value of P gives a timeout every P+1 cycles. In one-shot mode the counter stops at the period value and the timer returns to idle. A write to either period half clears the counter to zero. The stop command freezes the counter at its present value. The start command resumes counting from wherever the counter stands.

Control is a two-state machine:
- IDLE: the counter holds.
- RUN: the counter advances.
- Transition START: from IDLE to RUN, on a control write with the start bit set and the stop bit clear.
- Transition HALT: from RUN to IDLE, on a control write with the stop bit set.
- Transition EXPIRE: from RUN to IDLE, on a match in one-shot mode.
- Transition RELOAD: from RUN back to RUN, on a match in continuous mode.

Top module: `ivt_top`

## Requirements
- R1: After reset, every register reads zero: status, control, both period halves and both snapshot halves. The machine is in IDLE and `irq` is low.
- R2: A control write (address 1) with bit 2 (start) set and bit 3 (stop) clear moves IDLE to RUN. In RUN the count grows by one per cycle, and status bit 1 (running) reads 1.
- R3: A cycle in RUN with count equal to period sets status bit 0 (timeout) at the next edge. Any write to status (address 0) clears the flag. If the clear and a new match fall on the same edge, the flag stays set.
- R4: With control bit 1 (continuous) set, a match reloads the count to zero and the timer stays in RUN.
- R5: With control bit 1 clear, a match leaves the count at the period value, returns the timer to IDLE and clears the running bit.
- R6: A control write with bit 3 (stop) set returns RUN to IDLE without changing the count. The stop bit overrides a start bit written in the same access.
- R7: A write to address 2 (period bits 15:0) or address 3 (period bits 31:16) loads that half and clears the count to zero. Both halves read back at the same addresses.
- R8: A write to address 4 or 5 copies the current count into the snapshot. Address 4 reads snapshot bits 15:0 and address 5 reads bits 31:16.
- R9: `irq` is high exactly when the timeout flag and control bit 0 (interrupt enable) are both set.
- R10: Control reads return bit 0 (interrupt enable) and bit 1 (continuous) as stored, and bits 2 and 3 read zero. Addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The checker module tests these rules on every cycle:
- counting by one in RUN;
- holding in IDLE;
- timeout set on a match;
- reload in continuous mode;
- return to IDLE on a one-shot match;
- count cleared by a period write;
- `irq` never high without the timeout flag.

Only the bench scenarios can show the behaviour seen at the bus, because it depends on a sequence of writes and exact cycle counts:
- the snapshot values;
- stop overriding start;
- the set-wins collision between a match and a status clear;
- counting past 16 bits into the high half;
- register readback.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
    localparam logic [ADDR_W-1:0] A_PER_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_PER_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_SNP_LO = 3'd4;
    localparam logic [ADDR_W-1:0] A_SNP_HI = 3'd5;

    localparam int B_IEN   = 0;
    localparam int B_CONT  = 1;
    localparam int B_START = 2;
    localparam int B_STOP  = 3;

    localparam int B_TMO = 0;
    localparam int B_RUN = 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    output logic              irq_en,
    output logic              cont_mode,
    output logic              start_evt,
    output logic              stop_evt,
    output logic              status_wr,
    output logic              period_wr,
    output logic              snap_wr,
    output logic [CNT_W-1:0]  period
);
    logic ctrl_wr;

    always_comb begin
        ctrl_wr   = wr && (addr == A_CTRL);
        status_wr = wr && (addr == A_STATUS);
        period_wr = wr && ((addr == A_PER_LO) || (addr == A_PER_HI));
        snap_wr   = wr && ((addr == A_SNP_LO) || (addr == A_SNP_HI));
        start_evt = ctrl_wr && wdata[B_START];
        stop_evt  = ctrl_wr && wdata[B_STOP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en    <= 1'b0;
            cont_mode <= 1'b0;
        end else if (ctrl_wr) begin
            irq_en    <= wdata[B_IEN];
            cont_mode <= wdata[B_CONT];
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_per_half
        localparam logic [ADDR_W-1:0] HADDR = A_PER_LO + ADDR_W'(h);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                period[h*HALF_W +: HALF_W] <= '0;
            end else if (wr && (addr == HADDR)) begin
                period[h*HALF_W +: HALF_W] <= wdata;
            end
        end
    end
endmodule

// File: rtl/ivt_fsm.sv
module ivt_fsm
    import ivt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_evt,
    input  logic stop_evt,
    input  logic match,
    input  logic cont_mode,
    output logic running
);
    run_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_evt && !stop_evt) state_nx = ST_RUN;
            ST_RUN:  if (stop_evt || (match && !cont_mode)) state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        running = (state == ST_RUN);
    end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
    parameter int HALF_W = 16,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic             cont_mode,
    input  logic [CNT_W-1:0] period,
    input  logic             period_wr,
    input  logic             snap_wr,
    input  logic             status_wr,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] snapshot,
    output logic             match,
    output logic             timeout
);
    always_comb begin
        match = running && (count == period);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (period_wr) begin
            count <= '0;
        end else if (running) begin
            if (!match)        count <= count + CNT_W'(1);
            else if (cont_mode) count <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snapshot <= '0;
        else if (snap_wr) snapshot <= count;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         timeout <= 1'b0;
        else if (match)     timeout <= 1'b1;
        else if (status_wr) timeout <= 1'b0;
    end
endmodule

// File: rtl/ivt_top.sv
module ivt_top
    import ivt_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * HALF_W;

    logic             irq_en, cont_mode, start_evt, stop_evt;
    logic             status_wr, period_wr, snap_wr;
    logic             running, match, timeout;
    logic [CNT_W-1:0] period, count, snapshot;

    ivt_regs #(.HALF_W(HALF_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .irq_en(irq_en), .cont_mode(cont_mode), .start_evt(start_evt),
        .stop_evt(stop_evt), .status_wr(status_wr), .period_wr(period_wr),
        .snap_wr(snap_wr), .period(period)
    );

    ivt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .match(match), .cont_mode(cont_mode), .running(running)
    );

    ivt_counter #(.HALF_W(HALF_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .running(running), .cont_mode(cont_mode),
        .period(period), .period_wr(period_wr), .snap_wr(snap_wr),
        .status_wr(status_wr), .count(count), .snapshot(snapshot),
        .match(match), .timeout(timeout)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STATUS: begin
                bus_rdata[B_TMO] = timeout;
                bus_rdata[B_RUN] = running;
            end
            A_CTRL: begin
                bus_rdata[B_IEN]  = irq_en;
                bus_rdata[B_CONT] = cont_mode;
            end
            A_PER_LO: bus_rdata = period[HALF_W-1:0];
            A_PER_HI: bus_rdata = period[CNT_W-1:HALF_W];
            A_SNP_LO: bus_rdata = snapshot[HALF_W-1:0];
            A_SNP_HI: bus_rdata = snapshot[CNT_W-1:HALF_W];
            default:  bus_rdata = '0;
        endcase
    end

    always_comb begin
        irq = timeout && irq_en;
    end
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             cont_mode,
    input logic             stop_evt,
    input logic             period_wr,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period,
    input logic             timeout,
    input logic             irq
);
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (running && count != period && !period_wr) |=> count == $past(count) + CNT_W'(1));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !period_wr) |=> $stable(count));

    p_match_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && count == period) |=> timeout);

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && count == period && cont_mode && !stop_evt && !period_wr)
            |=> (count == '0 && running));

    p_oneshot_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && count == period && !cont_mode) |=> !running);

    p_period_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |=> count == '0);

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> timeout);
endmodule

bind ivt_top ivt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .cont_mode(cont_mode),
    .stop_evt(stop_evt), .period_wr(period_wr), .count(count), .period(period),
    .timeout(timeout), .irq(irq)
);

// File: tb/test_ivt_top.sv
`timescale 1ns/1ps
module test_ivt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    always #2 clk = ~clk;

    ivt_top i_ivt_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct {
        logic [2:0]  addr;
        logic [15:0] data;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    // monitor: compares one expected item per cycle, shortly after the negedge
    always @(negedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (bus_rdata !== e.data || irq !== e.irq) begin
                failures++;
                $display("FAIL %s addr=%0d rdata=%h irq=%b expected rdata=%h irq=%b",
                         e.tag, e.addr, bus_rdata, irq, e.data, e.irq);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] d, input logic i, input string tag);
        exp_t e;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        e.addr = a; e.data = d; e.irq = i; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bus_wr = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, 16'h0000, 0, "R1"); rd(1, 16'h0000, 0, "R1");
        rd(2, 16'h0000, 0, "R1"); rd(3, 16'h0000, 0, "R1");
        rd(4, 16'h0000, 0, "R1"); rd(5, 16'h0000, 0, "R1");

        // R2 / R8: count, snapshot
        wr(2, 16'd1000); wr(3, 16'd0);
        wr(1, 16'h0005);              // start, irq enable, one-shot
        idle(10);
        wr(4, 16'h0);                 // captures 10
        rd(4, 16'd10, 0, "R8");
        rd(5, 16'd0, 0, "R8");
        rd(0, 16'h0002, 0, "R2");
        // R6: stop holds count
        wr(1, 16'h0009);              // count 15 at this edge, then idle
        wr(4, 16'h0);
        rd(4, 16'd15, 0, "R6");
        rd(0, 16'h0000, 0, "R6");
        rd(1, 16'h0001, 0, "R10");
        wr(1, 16'h000D);              // start+stop: stop wins
        idle(3);
        wr(5, 16'h0);
        rd(4, 16'd15, 0, "R6");
        rd(0, 16'h0000, 0, "R6");

        // R5 one-shot period 4
        wr(2, 16'd4); wr(3, 16'd0);
        wr(1, 16'h0005);
        idle(3);
        rd(0, 16'h0002, 0, "R5");
        rd(0, 16'h0002, 0, "R3");
        rd(0, 16'h0001, 1, "R5");
        wr(4, 16'h0);
        rd(4, 16'd4, 1, "R5");
        wr(0, 16'hFFFF);
        rd(0, 16'h0000, 0, "R3");

        // R4 / R9 continuous period 2, irq disabled
        wr(2, 16'd2); wr(3, 16'd0);
        wr(1, 16'h0006);
        idle(2);
        rd(0, 16'h0002, 0, "R4");
        rd(0, 16'h0003, 0, "R9");
        wr(1, 16'h0003);              // enable irq, keep running
        rd(0, 16'h0003, 1, "R9");
        wr(0, 16'h0);
        rd(0, 16'h0002, 0, "R3");
        rd(0, 16'h0002, 0, "R4");
        rd(0, 16'h0003, 1, "R4");
        idle(1);
        wr(0, 16'h0);                 // clear on the match edge: set wins
        rd(0, 16'h0003, 1, "R3");
        wr(1, 16'h000B);              // stop
        rd(1, 16'h0003, 1, "R10");
        wr(0, 16'h0);
        rd(0, 16'h0000, 0, "R6");

        // R7 period readback and count clear
        wr(2, 16'h1234);
        rd(2, 16'h1234, 0, "R7");
        rd(3, 16'h0000, 0, "R7");
        wr(4, 16'h0);
        rd(4, 16'h0000, 0, "R7");

        // R8 high half: period 0x0001_0000 one-shot
        wr(2, 16'h0000); wr(3, 16'h0001);
        rd(3, 16'h0001, 0, "R7");
        wr(1, 16'h0005);
        idle(65540);
        wr(5, 16'h0);
        rd(5, 16'h0001, 1, "R8");
        rd(4, 16'h0000, 1, "R8");
        rd(0, 16'h0001, 1, "R5");

        // R10 unmapped
        rd(6, 16'h0000, 1, "R10");
        rd(7, 16'h0000, 1, "R10");

        idle(4);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule